// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 12-bit successive-approximation converter. Software drives it through a small control write port. That port turns the module on or off, requests or cancels a conversion, and picks the conversion-clock source and the acquisition length. The block times every phase from one conversion-clock period (Tad). Tad is either a power-of-two division of the system clock or a tick from a free-running RC oscillator. The phases are warm-up after enabling, discharge of the holding element, sampling, optional automatic acquisition, bitwise approximation and recovery.

During approximation the block drives a trial code to the DAC and reads back a single comparator bit. Bits are decided from the most significant down. When the conversion completes, the block loads the result register, drops the busy/start flag and raises an interrupt flag, all on the same edge. Software can cancel a conversion in flight, and the previous result is then kept. An external event trigger can also start a conversion. Each such trigger is echoed as a one-cycle timer-reset pulse, whether or not the trigger is accepted.

Top module: `sar_seq`

## Requirements
- R1: The clock code selects Tad as a multiple of the system clock: 000=2, 100=4, 001=8, 101=16, 010=32, 110=64 cycles. With manual acquisition, a start written at edge e0 clears start_flag at edge e0+13·Tad.
- R2: Any clock code with bits [1:0]=11 makes Tad one rc_tick pulse. An extra ICYC system cycles are inserted before Tad counting begins. While no rc_tick arrives, a conversion stays busy.
- R3: Acquisition code 000 is manual: an accepted start stops sampling at the next edge and begins the 13-Tad conversion.
- R4: A nonzero acquisition code keeps sampling after the start for 001=2, 010=4, 011=6, 100=8, 101=12, 110=16 or 111=20 Tad, then converts. The total latency is (acquisition + 13)·Tad.
- R5: Bits are decided MSB first, with a bit kept when cmp_in=1 (input at or above dac_code). The final result equals the input code, from 0 to 4095.
- R6: On completion, result is loaded, start_flag clears and irq_flag sets on the same edge. irq_flag then holds until irq_clr.
- R7: A control write with ctl_on=1 and ctl_go=0 while busy aborts. result keeps its previous value, start_flag clears and irq_flag is not set.
- R8: After a completion or an abort, the block waits 2·ICYC system cycles. It then raises discharge for one cycle and then resumes sampling, so sample_on returns 2·ICYC+1 cycles after the completion edge. Starts during that wait are ignored.
- R9: sample_on is low during conversion and during the manual-mode insertion cycle. It stays high during automatic acquisition.
- R10: trig_in starts a conversion only when the module is on and sampling. tmr_reset pulses on the cycle after every trig_in, even while the module is off.
- R11: A start written in the same cycle as enabling is ignored. So is any start during the first 3 Tad after enabling.
- R12: rst_n turns the module off and aborts a conversion but leaves result unchanged. Only por_n clears result to 0.
- R13: A result write (res_we) loads res_wdata when no completion occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| por_n | input | 1 | Asynchronous active-low power-on reset of the result register |
| ctl_we | input | 1 | Control write strobe |
| ctl_on | input | 1 | Module enable value written |
| ctl_go | input | 1 | Start (1) or cancel (0) value written |
| ctl_clk_sel | input | 3 | Conversion clock code |
| ctl_acq_sel | input | 3 | Acquisition length code |
| res_we | input | 1 | Result register write strobe |
| res_wdata | input | 12 | Result write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| trig_in | input | 1 | External start event |
| rc_tick | input | 1 | One-cycle pulse per RC oscillator period |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| dac_code | output | 12 | Trial code for the DAC |
| sample_on | output | 1 | Sample switch closed |
| discharge | output | 1 | Holding element discharge |
| start_flag | output | 1 | Busy/start flag |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| result | output | 12 | Last result |
| tmr_reset | output | 1 | Timer reset pulse following a trigger |

## Verification
The hardest cases to reach from the ports are the conversions that must not happen. One is a start that lands inside warm-up or recovery. Another is a trigger while the module is off. A third is an RC-clocked conversion stalled with no tick. The bench reaches these by issuing control writes on the very cycle after enabling or after a completion, and by gating its own RC tick generator off. It also sweeps all six divided clock codes against all eight acquisition codes and checks latency, result and recovery length for each combination.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_WARM, ST_DISCH, ST_SAMPLE, ST_DELAY, ST_ACQ, ST_CONV, ST_RECOV
  } sar_st_e;

  function automatic logic is_rc(input logic [2:0] code);
    return code[1:0] == 2'b11;
  endfunction

  // log2(Tad / Tosc) - 1 for divided codes
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return {code[1:0], 1'b0} + {2'b00, code[2]};
  endfunction

  function automatic logic [4:0] acq_tads(input logic [2:0] code);
    case (code)
      3'd1: return 5'd2;
      3'd2: return 5'd4;
      3'd3: return 5'd6;
      3'd4: return 5'd8;
      3'd5: return 5'd12;
      3'd6: return 5'd16;
      3'd7: return 5'd20;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
  import sar_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] sel,
  input  logic       rc_tick,
  output logic       tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             osc_wrap;

  assign lim      = DIV_W'((2 << div_shift(sel)) - 1);
  assign osc_wrap = (cnt_q >= lim);
  assign tick     = is_rc(sel) ? rc_tick : osc_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr || osc_wrap)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] code
);
  logic [W-1:0] code_q;
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (load) begin
      code_q <= {1'b1, {(W-1){1'b0}}};
      mask_q <= {1'b1, {(W-1){1'b0}}};
    end else if (step) begin
      code_q <= (cmp ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int ICYC  = 4,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             ctl_we,
  input  logic             ctl_on,
  input  logic             ctl_go,
  input  logic [2:0]       ctl_clk_sel,
  input  logic [2:0]       ctl_acq_sel,
  input  logic             res_we,
  input  logic [RES_W-1:0] res_wdata,
  input  logic             irq_clr,
  input  logic             trig_in,
  input  logic             rc_tick,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_on,
  output logic             discharge,
  output logic             start_flag,
  output logic             irq_flag,
  output logic [RES_W-1:0] result,
  output logic             tmr_reset
);
  localparam int TAD_W = $clog2(RES_W + 21);
  localparam int CNT_W = $clog2(2 * ICYC + 1);

  sar_st_e          st, nxt;
  logic [2:0]       clk_sel_q, acq_sel_q, eff_clk, eff_acq;
  logic [TAD_W-1:0] tad_cnt;
  logic [CNT_W-1:0] cyc_cnt;
  logic             irq_q, tmr_q;
  logic [RES_W-1:0] res_q;

  // named internal events
  logic tad_tick, tad_clr, busy, wr_off, sw_go, sw_abort;
  logic start_evt, abort_evt, done_evt, warming, conv_enter, conv_step;

  assign wr_off   = ctl_we && !ctl_on;
  assign sw_go    = ctl_we && ctl_on && ctl_go;
  assign sw_abort = ctl_we && ctl_on && !ctl_go;
  assign eff_clk  = ctl_we ? ctl_clk_sel : clk_sel_q;
  assign eff_acq  = ctl_we ? ctl_acq_sel : acq_sel_q;
  assign busy     = (st == ST_DELAY) || (st == ST_ACQ) || (st == ST_CONV);
  assign warming  = (st == ST_WARM);

  assign start_evt = (st == ST_SAMPLE) && (sw_go || trig_in) && !wr_off;
  assign abort_evt = busy && sw_abort;
  assign done_evt  = (st == ST_CONV) && tad_tick && (tad_cnt == TAD_W'(RES_W))
                     && !sw_abort && !wr_off;

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF:    if (ctl_we && ctl_on) nxt = ST_WARM;
      ST_WARM:   if (tad_tick && tad_cnt == TAD_W'(2)) nxt = ST_DISCH;
      ST_DISCH:  nxt = ST_SAMPLE;
      ST_SAMPLE: if (start_evt) begin
                   if (is_rc(eff_clk))             nxt = ST_DELAY;
                   else if (acq_tads(eff_acq) != 0) nxt = ST_ACQ;
                   else                             nxt = ST_CONV;
                 end
      ST_DELAY:  if (cyc_cnt == CNT_W'(ICYC - 1))
                   nxt = (acq_tads(acq_sel_q) != 0) ? ST_ACQ : ST_CONV;
      ST_ACQ:    if (tad_tick && tad_cnt == TAD_W'(acq_tads(acq_sel_q)) - 1'b1)
                   nxt = ST_CONV;
      ST_CONV:   if (done_evt) nxt = ST_RECOV;
      ST_RECOV:  if (cyc_cnt == CNT_W'(2 * ICYC - 1)) nxt = ST_DISCH;
      default:   nxt = ST_OFF;
    endcase
    if (abort_evt) nxt = ST_RECOV;
    if (wr_off)    nxt = ST_OFF;
  end

  assign tad_clr    = (nxt != st);
  assign conv_enter = (nxt == ST_CONV) && (st != ST_CONV);
  assign conv_step  = (st == ST_CONV) && tad_tick && (tad_cnt < TAD_W'(RES_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      clk_sel_q <= '0;
      acq_sel_q <= '0;
      tad_cnt   <= '0;
      cyc_cnt   <= '0;
      irq_q     <= 1'b0;
      tmr_q     <= 1'b0;
    end else begin
      st    <= nxt;
      tmr_q <= trig_in;
      if (ctl_we) begin
        clk_sel_q <= ctl_clk_sel;
        acq_sel_q <= ctl_acq_sel;
      end
      if (tad_clr)       tad_cnt <= '0;
      else if (tad_tick) tad_cnt <= tad_cnt + 1'b1;
      if (tad_clr) cyc_cnt <= '0;
      else         cyc_cnt <= cyc_cnt + 1'b1;
      if (done_evt)     irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  // result survives module reset; only power-on clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        res_q <= '0;
    else if (done_evt) res_q <= dac_code;
    else if (res_we)   res_q <= res_wdata;
  end

  sar_tad_gen #(.DIV_W(DIV_W)) u_tad (
    .clk(clk), .rst_n(rst_n), .clr(tad_clr), .sel(clk_sel_q),
    .rc_tick(rc_tick), .tick(tad_tick)
  );

  sar_core #(.W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(conv_enter), .step(conv_step),
    .cmp(cmp_in), .code(dac_code)
  );

  assign sample_on  = (st == ST_SAMPLE) || (st == ST_ACQ) ||
                      ((st == ST_DELAY) && (acq_sel_q != 3'd0));
  assign discharge  = (st == ST_DISCH);
  assign start_flag = busy;
  assign irq_flag   = irq_q;
  assign result     = res_q;
  assign tmr_reset  = tmr_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_evt,
  input logic             abort_evt,
  input logic             warming,
  input logic             res_we,
  input logic             trig_in,
  input logic             irq_flag,
  input logic             start_flag,
  input logic             sample_on,
  input logic             discharge,
  input logic             tmr_reset,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] dac_code
);
  // R6: completion loads result, clears busy and flags interrupt together
  a_r6_done_together: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (irq_flag && !start_flag && result == dac_code));

  // R7: abort leaves the result alone and drops busy
  a_r7_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !res_we) |=> ($stable(result) && !start_flag));

  // R8: recovery follows completion with sampling and discharge both off
  a_r8_recover_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!sample_on && !discharge));

  // R10: every trigger echoes as a timer reset pulse
  a_r10_tmr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_in |=> tmr_reset);

  // R11: nothing starts while warming up
  a_r11_warm_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    warming |=> !start_flag);
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .abort_evt(abort_evt),
  .warming(warming), .res_we(res_we), .trig_in(trig_in), .irq_flag(irq_flag),
  .start_flag(start_flag), .sample_on(sample_on), .discharge(discharge),
  .tmr_reset(tmr_reset), .result(result), .dac_code(dac_code)
);

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;
  localparam int ICYC = 4;
  logic clk = 0, rst_n = 0, por_n = 0;
  logic ctl_we = 0, ctl_on = 0, ctl_go = 0;
  logic [2:0] ctl_clk_sel = 0, ctl_acq_sel = 0;
  logic res_we = 0, irq_clr = 0, trig_in = 0, rc_tick = 0, rc_run = 0;
  logic [11:0] res_wdata = 0, vin = 0;
  logic cmp_in;
  logic [11:0] dac_code, result;
  logic sample_on, discharge, start_flag, irq_flag, tmr_reset;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;
  assign cmp_in = (dac_code <= vin);

  sar_seq #(.RES_W(12), .ICYC(ICYC), .DIV_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .ctl_we(ctl_we), .ctl_on(ctl_on),
    .ctl_go(ctl_go), .ctl_clk_sel(ctl_clk_sel), .ctl_acq_sel(ctl_acq_sel),
    .res_we(res_we), .res_wdata(res_wdata), .irq_clr(irq_clr), .trig_in(trig_in),
    .rc_tick(rc_tick), .cmp_in(cmp_in), .dac_code(dac_code), .sample_on(sample_on),
    .discharge(discharge), .start_flag(start_flag), .irq_flag(irq_flag),
    .result(result), .tmr_reset(tmr_reset)
  );

  initial begin : rc_gen
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      rc_tick = rc_run && (k % 7 == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int acq_len(input int a);
    if (a == 0) return 0;
    if (a <= 4) return 2 * a;
    return 4 * a - 8;
  endfunction

  task automatic ctl(input bit on, input bit go, input logic [2:0] cs, input logic [2:0] as);
    @(negedge clk);
    ctl_we = 1; ctl_on = on; ctl_go = go; ctl_clk_sel = cs; ctl_acq_sel = as;
    @(negedge clk);
    ctl_we = 0; ctl_go = 0;
  endtask

  task automatic wait_sample(output int n, output int disc);
    n = 0; disc = 0;
    while (!sample_on && n < 20000) begin
      @(negedge clk); n++;
      if (discharge) disc++;
    end
  endtask

  task automatic bring_up(input logic [2:0] cs, input logic [2:0] as);
    int n, d;
    ctl(0, 0, cs, as);
    ctl(1, 0, cs, as);
    wait_sample(n, d);
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (start_flag && lat < 20000) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1;
    @(negedge clk); trig_in = 0;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int lat, n, d, prev;
    logic [2:0] cs;
    repeat (3) @(negedge clk);
    chk(!start_flag && !irq_flag && !sample_on && result == 0, "R12 reset", start_flag, 0);
    rst_n = 1; por_n = 1;

    // R11: start together with enable, and during warm-up, ignored
    ctl(1, 1, 3'b110, 0);
    chk(start_flag == 0, "R11 same-cycle start", start_flag, 0);
    ctl(1, 1, 3'b110, 0);
    chk(start_flag == 0, "R11 warm-up start", start_flag, 0);
    wait_sample(n, d);
    chk(n >= 3 * 64 - 4, "R11 warm-up length", n, 3 * 64);

    // R1 R3 R4 R5 R6 R8: sweep divided clocks x acquisition codes
    for (int s = 0; s < 6; s++) begin
      cs = 3'(((s & 1) << 2) | (s >> 1));
      bring_up(cs, 0);
      for (int a = 0; a < 8; a++) begin
        vin = 12'(((s * 8 + a) * 1237 + 5) % 4096);
        if (s == 0 && a == 0) vin = 0;
        if (s == 5 && a == 7) vin = 12'hFFF;
        ctl(1, 1, cs, 3'(a));
        chk(start_flag == 1, "R3 start accepted", start_flag, 1);
        if (a == 0) chk(sample_on == 0, "R3 sampling stops", sample_on, 0);
        else        chk(sample_on == 1, "R4 acquiring", sample_on, 1);
        wait_done(lat);
        chk(lat == (acq_len(a) + 13) * (2 << s), a == 0 ? "R1 latency" : "R4 latency",
            lat, (acq_len(a) + 13) * (2 << s));
        chk(result == vin, "R5 result", result, vin);
        chk(irq_flag == 1, "R6 irq set", irq_flag, 1);
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk(irq_flag == 0, "R6 irq clear", irq_flag, 1);
        wait_sample(n, d);
        chk(n == 2 * ICYC + 1 - 2 && d == 1, "R8 recovery", n, 2 * ICYC - 1);
      end
    end

    // R8: start issued immediately after completion is ignored
    bring_up(3'b000, 0);
    vin = 12'd321;
    ctl(1, 1, 3'b000, 0);
    wait_done(lat);
    ctl(1, 1, 3'b000, 0);
    chk(start_flag == 0, "R8 start in recovery", start_flag, 0);
    wait_sample(n, d);

    // R7 R13: abort keeps the result, software write lands
    vin = 12'd1000;
    ctl(1, 1, 3'b000, 0); wait_done(lat);
    prev = result;
    vin = 12'd3000;
    ctl(1, 1, 3'b000, 0);
    repeat (10) @(negedge clk);
    ctl(1, 0, 3'b000, 0);
    chk(start_flag == 0, "R7 abort busy", start_flag, 0);
    chk(result == prev, "R7 abort keeps result", result, prev);
    chk(irq_flag == 1, "R7 prior irq untouched", irq_flag, 1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    wait_sample(n, d);
    @(negedge clk); res_we = 1; res_wdata = 12'h5A5; @(negedge clk); res_we = 0;
    chk(result == 12'h5A5, "R13 result write", result, 12'h5A5);
    ctl(1, 1, 3'b000, 3'd7);
    repeat (5) @(negedge clk);
    ctl(1, 0, 3'b000, 3'd7);
    chk(result == 12'h5A5 && irq_flag == 0, "R7 abort in acquisition", result, 12'h5A5);
    wait_sample(n, d);

    // R10: trigger while off ignored, timer pulse still given
    ctl(0, 0, 3'b000, 0);
    pulse_trig();
    chk(tmr_reset == 1, "R10 timer pulse off", tmr_reset, 1);
    chk(start_flag == 0 && sample_on == 0, "R10 trigger ignored", start_flag, 0);
    @(negedge clk);
    chk(tmr_reset == 0, "R10 single pulse", tmr_reset, 0);
    bring_up(3'b000, 0);
    vin = 12'd777;
    pulse_trig();
    chk(start_flag == 1 && tmr_reset == 1, "R10 trigger starts", start_flag, 1);
    wait_done(lat);
    chk(result == 777, "R10 trigger result", result, 777);

    // R2 R9: RC clock
    rc_run = 1;
    bring_up(3'b011, 0);
    rc_run = 0;
    vin = 12'd2222;
    ctl(1, 1, 3'b011, 0);
    chk(sample_on == 0, "R9 manual rc stops sampling", sample_on, 0);
    repeat (300) @(negedge clk);
    chk(start_flag == 1, "R2 rc stalls without tick", start_flag, 1);
    rc_run = 1;
    wait_done(lat);
    chk(result == 2222 && start_flag == 0, "R2 rc result", result, 2222);
    wait_sample(n, d);
    vin = 12'd55;
    ctl(1, 1, 3'b111, 3'd2);
    chk(sample_on == 1 && start_flag == 1, "R9 rc auto keeps sampling", sample_on, 1);
    wait_done(lat);
    chk(result == 55 && lat > ICYC + 17 * 7 - 14, "R2 rc auto result", result, 55);
    rc_run = 0;
    wait_sample(n, d);

    // R12: reset aborts but keeps result; power-on clears
    ctl(1, 0, 3'b000, 0);
    wait_sample(n, d);
    vin = 12'd4000;
    ctl(1, 1, 3'b000, 0);
    repeat (5) @(negedge clk);
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk(start_flag == 0 && sample_on == 0, "R12 reset turns off", start_flag, 0);
    chk(result == 55, "R12 result kept", result, 55);
    repeat (10) @(negedge clk);
    chk(sample_on == 0, "R12 stays off", sample_on, 0);
    por_n = 0; @(negedge clk); por_n = 1;
    chk(result == 0, "R12 power-on clears", result, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule